// File: doc/BRIEF.md
# Accumulator Processor Core with Micro-Operation Opcode

A compact processor core built around one accumulator, an auxiliary register and a program counter. Instructions and data share one internal synchronous memory. Each instruction goes through three phases in a fixed order: fetch, decode with operand read, and execute with write-back. Every instruction therefore takes exactly three clock cycles while the run enable is high. When the run enable is low the core holds all of its state.

The memory is filled through a load port, and the core accepts a load only while it is stopped. The core offers four memory-reference operations and one register operation. The memory-reference operations are add, store-then-clear, increment-memory-and-skip-if-zero, and jump. In the register operation, three flag bits select an accumulator increment, a skip when the accumulator is zero, and an exchange of the accumulator with the auxiliary register. The three actions always happen in that order within the one instruction.

Instruction word layout: bits 15..13 hold the opcode. Bit 12 is flag F0, bit 11 is flag F1 and bit 10 is flag F2. Bits 9..0 hold the address field. All data arithmetic is 16 bits wide and wraps modulo 2^16. The program counter wraps modulo 2^10.

Top module: `acc_core`

## Requirements
- R1: While reset is active (rst_n low), PC, AC and AX are cleared to zero and the core returns to the fetch phase, so idle_o is 1.
- R2: With run high, each instruction takes exactly three cycles. idle_o is 1 at the start of an instruction and 0 for the two cycles that follow.
- R3: While run is low, PC, AC, AX and the instruction phase do not change. Execution resumes in the same phase when run goes high again.
- R4: Opcode 0 adds the memory word at the address field to AC, modulo 2^16, and advances PC by one.
- R5: Opcode 1 writes AC to memory at the address field, then sets AC to zero and advances PC by one.
- R6: Opcode 2 writes the memory word plus one (mod 2^16) back to the address field. PC advances by two if the new value is zero and by one otherwise.
- R7: Opcode 3 loads PC with the address field.
- R8: Opcodes 4, 5 and 6 leave AC and AX unchanged and advance PC by one.
- R9: In opcode 7, when F0 (bit 12) is set, AC is incremented modulo 2^16.
- R10: In opcode 7, when F1 (bit 11) is set and AC is zero after the F0 step, PC advances by two; otherwise PC advances by one.
- R11: In opcode 7, when F2 (bit 10) is set, AX receives the AC value from after the F0 step, and AC receives the old AX.
- R12: A load_en pulse writes load_data to memory at load_addr only while run is low. A pulse while run is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run enable; low freezes the core |
| load_en | input | 1 | Memory preload write strobe |
| load_addr | input | 10 | Memory preload address |
| load_data | input | 16 | Memory preload data |
| pc_o | output | 10 | Program counter |
| ac_o | output | 16 | Accumulator |
| ax_o | output | 16 | Auxiliary register |
| idle_o | output | 1 | High in the fetch phase (instruction boundary) |

## Verification
The assertions assume that reset is applied before the first run and that run is a plain level, free to change in any cycle. They also assume that preloaded memory holds only intended program words at the addresses the program reaches. The stimulus changes every input on the falling clock edge. It loads each program while the core is stopped, and it stops the core only after a whole number of three-cycle instructions, with one exception: the freeze test stops it on purpose in the middle of an instruction. Memory effects are observed by reading the written word back into AC with a later add.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OP_W   = 3;
    localparam int FLAG_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_STCLR = 3'd1,
        OP_INCSK = 3'd2,
        OP_JUMP  = 3'd3,
        OP_IDLE4 = 3'd4,
        OP_IDLE5 = 3'd5,
        OP_IDLE6 = 3'd6,
        OP_MICRO = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data_q <= store_q[rd_addr];
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  opcode_e           op,
    input  logic              f_inc,
    input  logic              f_skz,
    input  logic              f_swap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] ax,
    input  logic [DATA_W-1:0] opnd,
    output logic [ADDR_W-1:0] pc_next,
    output logic [DATA_W-1:0] ac_next,
    output logic [DATA_W-1:0] ax_next,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [ADDR_W-1:0] pc_one;
    logic [ADDR_W-1:0] pc_two;
    logic [DATA_W-1:0] bumped;
    logic [DATA_W-1:0] stage_ac;

    always_comb begin
        pc_one    = pc + 1'b1;
        pc_two    = pc + 2'd2;
        bumped    = opnd + 1'b1;
        stage_ac  = f_inc ? ac + 1'b1 : ac;
        pc_next   = pc_one;
        ac_next   = ac;
        ax_next   = ax;
        mem_we    = 1'b0;
        mem_wdata = ac;
        unique case (op)
            OP_ADD: ac_next = ac + opnd;
            OP_STCLR: begin
                mem_we    = 1'b1;
                mem_wdata = ac;
                ac_next   = '0;
            end
            OP_INCSK: begin
                mem_we    = 1'b1;
                mem_wdata = bumped;
                pc_next   = (bumped == '0) ? pc_two : pc_one;
            end
            OP_JUMP: pc_next = addr;
            OP_MICRO: begin
                pc_next = (f_skz && stage_ac == '0) ? pc_two : pc_one;
                if (f_swap) begin
                    ac_next = ax;
                    ax_next = stage_ac;
                end else begin
                    ac_next = stage_ac;
                end
            end
            OP_IDLE4, OP_IDLE5, OP_IDLE6: pc_next = pc_one;
        endcase
    end

    // R11: exchange hands AX the post-increment accumulator value
    always_comb begin
        if (op == OP_MICRO && f_swap) begin
            p_swap_order_r11: assert (ax_next - ac == {{(DATA_W-1){1'b0}}, f_inc})
                else $error("swap did not carry the incremented AC");
        end
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] ac_o,
    output logic [DATA_W-1:0] ax_o,
    output logic              idle_o
);
    localparam int OP_LSB   = DATA_W - OP_W;
    localparam int FINC_BIT = OP_LSB - 1;
    localparam int FSKZ_BIT = OP_LSB - 2;
    localparam int FSWP_BIT = OP_LSB - FLAG_W;

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] ax;
        logic [DATA_W-1:0] ir;
    } core_s;

    core_s core_d, core_q;

    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              mem_wr;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata_mux;

    opcode_e           op;
    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] ex_pc;
    logic [DATA_W-1:0] ex_ac;
    logic [DATA_W-1:0] ex_ax;
    logic              ex_we;
    logic [DATA_W-1:0] ex_wdata;
    logic              in_exec;

    assign op      = opcode_e'(core_q.ir[DATA_W-1 -: OP_W]);
    assign ir_addr = core_q.ir[ADDR_W-1:0];
    assign in_exec = run && (core_q.ph == PH_EXEC);

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rd_en   (run),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (mem_wr),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata_mux)
    );

    acc_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exec (
        .op        (op),
        .f_inc     (core_q.ir[FINC_BIT]),
        .f_skz     (core_q.ir[FSKZ_BIT]),
        .f_swap    (core_q.ir[FSWP_BIT]),
        .addr      (ir_addr),
        .pc        (core_q.pc),
        .ac        (core_q.ac),
        .ax        (core_q.ax),
        .opnd      (rd_data),
        .pc_next   (ex_pc),
        .ac_next   (ex_ac),
        .ax_next   (ex_ax),
        .mem_we    (ex_we),
        .mem_wdata (ex_wdata)
    );

    always_comb begin
        core_d  = core_q;
        rd_addr = (core_q.ph == PH_FETCH) ? core_q.pc : rd_data[ADDR_W-1:0];
        if (run) begin
            unique case (core_q.ph)
                PH_FETCH:  core_d.ph = PH_DECODE;
                PH_DECODE: begin
                    core_d.ir = rd_data;
                    core_d.ph = PH_EXEC;
                end
                PH_EXEC: begin
                    core_d.pc = ex_pc;
                    core_d.ac = ex_ac;
                    core_d.ax = ex_ax;
                    core_d.ph = PH_FETCH;
                end
                default:   core_d.ph = PH_FETCH;
            endcase
        end
        mem_wr        = in_exec ? ex_we : (load_en && !run);
        mem_waddr     = run ? ir_addr : load_addr;
        mem_wdata_mux = run ? ex_wdata : load_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.ph <= PH_FETCH;
            core_q.pc <= '0;
            core_q.ac <= '0;
            core_q.ax <= '0;
            core_q.ir <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign pc_o   = core_q.pc;
    assign ac_o   = core_q.ac;
    assign ax_o   = core_q.ax;
    assign idle_o = (core_q.ph == PH_FETCH);

    p_three_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && idle_o) |=> !idle_o)
        else $error("instruction boundary repeated too early");

    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(pc_o) && $stable(ac_o) && $stable(ax_o) && $stable(idle_o)))
        else $error("state moved while stopped");

    p_store_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == OP_STCLR) |=> (ac_o == '0))
        else $error("AC not cleared after store");

    p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == OP_JUMP) |=> (pc_o == $past(ir_addr)))
        else $error("jump target wrong");

    p_idle_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && (op == OP_IDLE4 || op == OP_IDLE5 || op == OP_IDLE6))
        |=> ($stable(ac_o) && $stable(ax_o) && pc_o == $past(pc_o) + 1'b1))
        else $error("idle opcode changed registers");

    p_no_load_running_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !in_exec) |-> !mem_wr)
        else $error("memory written outside execute while running");

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
    localparam int DW = 16;
    localparam int AW = 10;
    localparam int NCASE = 13;
    localparam int NCOL = 10;

    // columns: word0..word3, mem[100], mem[101], instructions, pc, ac, ax
    localparam logic [15:0] CASES [NCASE][NCOL] = '{
        '{16'h0064, 16'h0065, 16'h0000, 16'h0000, 16'h0005, 16'h0007, 16'd2, 16'd2, 16'h000C, 16'h0000},
        '{16'h0064, 16'h0065, 16'h0000, 16'h0000, 16'hFFFF, 16'h0002, 16'd2, 16'd2, 16'h0001, 16'h0000},
        '{16'h0064, 16'h2066, 16'h0066, 16'h0000, 16'h1234, 16'h0000, 16'd3, 16'd3, 16'h1234, 16'h0000},
        '{16'h4064, 16'h0064, 16'h0000, 16'h0000, 16'h0005, 16'h0000, 16'd2, 16'd2, 16'h0006, 16'h0000},
        '{16'h4064, 16'hF000, 16'h0065, 16'h0064, 16'hFFFF, 16'h0009, 16'd3, 16'd4, 16'h0009, 16'h0000},
        '{16'h6003, 16'hF000, 16'hF000, 16'h0064, 16'h0055, 16'h0000, 16'd2, 16'd4, 16'h0055, 16'h0000},
        '{16'h8000, 16'hA000, 16'hC000, 16'h0064, 16'h0003, 16'h0000, 16'd4, 16'd4, 16'h0003, 16'h0000},
        '{16'h0064, 16'hF000, 16'h0000, 16'h0000, 16'h0010, 16'h0000, 16'd2, 16'd2, 16'h0011, 16'h0000},
        '{16'h0064, 16'hF800, 16'hF000, 16'h0065, 16'hFFFF, 16'h0004, 16'd3, 16'd4, 16'h0004, 16'h0000},
        '{16'hE800, 16'hF000, 16'h0065, 16'h0000, 16'h0000, 16'h0006, 16'd2, 16'd3, 16'h0006, 16'h0000},
        '{16'h0064, 16'hE800, 16'hF000, 16'h0000, 16'hFFFF, 16'h0000, 16'd3, 16'd3, 16'h0000, 16'h0000},
        '{16'h0064, 16'hE400, 16'h0065, 16'hF400, 16'h0007, 16'h0002, 16'd4, 16'd4, 16'h0007, 16'h0003},
        '{16'h0064, 16'hE400, 16'h0065, 16'hFC00, 16'h0005, 16'hFFFF, 16'd4, 16'd5, 16'h0005, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] ac_o;
    logic [DW-1:0] ax_o;
    logic          idle_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acc_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .pc_o      (pc_o),
        .ac_o      (ac_o),
        .ax_o      (ax_o),
        .idle_o    (idle_o)
    );

    function automatic string tag_of(int i);
        case (i)
            0, 1:     return "R4";
            2:        return "R5";
            3, 4:     return "R6";
            5:        return "R7";
            6:        return "R8";
            7:        return "R9";
            8, 9, 10: return "R10";
            default:  return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run = 1'b0;
        load_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(logic [AW-1:0] a, logic [DW-1:0] d);
        load_en = 1'b1;
        load_addr = a;
        load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_for(int n);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        do_reset();
        check("R1", "pc", 32'(pc_o), 0);
        check("R1", "ac", 32'(ac_o), 0);
        check("R1", "ax", 32'(ax_o), 0);
        check("R1", "idle", 32'(idle_o), 1);

        // table of short programs
        for (int i = 0; i < NCASE; i++) begin
            do_reset();
            for (int w = 0; w < 4; w++) load(AW'(w), CASES[i][w]);
            load(AW'(100), CASES[i][4]);
            load(AW'(101), CASES[i][5]);
            run_for(3 * int'(CASES[i][6]));
            check(tag_of(i), "pc", 32'(pc_o), 32'(CASES[i][7]));
            check(tag_of(i), "ac", 32'(ac_o), 32'(CASES[i][8]));
            check(tag_of(i), "ax", 32'(ax_o), 32'(CASES[i][9]));
            check("R2", "idle at boundary", 32'(idle_o), 1);
        end

        // R2: three-cycle rhythm
        do_reset();
        load(0, 16'h0064);
        load(100, 16'h0001);
        run = 1'b1;
        check("R2", "idle cycle0", 32'(idle_o), 1);
        @(negedge clk);
        check("R2", "idle cycle1", 32'(idle_o), 0);
        @(negedge clk);
        check("R2", "idle cycle2", 32'(idle_o), 0);
        @(negedge clk);
        check("R2", "idle cycle3", 32'(idle_o), 1);
        run = 1'b0;

        // R3: freeze mid-instruction, then resume
        do_reset();
        load(0, 16'h0064);
        load(1, 16'h0065);
        load(100, 16'h0005);
        load(101, 16'h0007);
        run_for(4);
        repeat (6) @(negedge clk);
        check("R3", "pc frozen", 32'(pc_o), 1);
        check("R3", "ac frozen", 32'(ac_o), 5);
        check("R3", "phase frozen", 32'(idle_o), 0);
        run_for(2);
        check("R3", "ac resumed", 32'(ac_o), 12);
        check("R3", "pc resumed", 32'(pc_o), 2);
        check("R3", "idle resumed", 32'(idle_o), 1);

        // R12: a load while running is ignored
        do_reset();
        load(0, 16'h0064);
        load(100, 16'h0004);
        run = 1'b1;
        load_en = 1'b1;
        load_addr = AW'(100);
        load_data = 16'h0099;
        @(negedge clk);
        load_en = 1'b0;
        repeat (2) @(negedge clk);
        run = 1'b0;
        check("R12", "ac after ignored load", 32'(ac_o), 4);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule